// File: doc/BRIEF.md
# EEPROM Page Buffer and Write Sequencer

This block sits behind a two-wire serial slave front end and owns everything between that front end and a 1024 x 8 memory array: the 10-bit word pointer, a 16-byte staging buffer with a per-byte valid mask, and the timed internal write cycle. The front end decodes the bus and hands over single-cycle commands: load the pointer, deliver a received data byte, fetch a byte to transmit, or signal a stop condition. The block answers with read data and a busy flag. The front end uses the busy flag to withhold its acknowledge while a write is in progress.

Received bytes are staged in the buffer and are not written to the array yet. A stop condition with at least one staged byte and write protect low starts a busy window of `BUSY_CYCLES` clocks. The staged bytes are copied into the array during the last `PAGE_BYTES` clocks of that window, so the array shows the new data only once busy drops. Writes wrap inside the current page. Reads walk the whole array and wrap from the top address to zero.

Top module: `eeprom_page_sequencer`

## Requirements
- R1: After reset, busy and rd_valid are low, the pointer is 0 and every array location reads as 0x00.
- R2: A read request accepted while idle gives rd_valid high on the next cycle, with rd_data equal to the array byte at the pointer. The whole 10-bit pointer then increments, and address 1023 is followed by address 0.
- R3: A pointer load sets the pointer to addr_in. A stop that follows a load with no data byte (a dummy write) starts no busy window, and a later read returns the loaded location.
- R4: A data byte accepted while idle with write protect low is staged at the lane given by pointer bits [3:0]. Only those four bits then increment, so bits [9:4] never change. A seventeenth byte therefore overwrites the first one.
- R5: A write commits only the lanes that received a byte. The other locations of the page keep their old contents.
- R6: A stop accepted while idle, with at least one staged byte and wp low, raises busy on the next cycle. Busy then stays high for exactly BUSY_CYCLES cycles.
- R7: With wp high, data bytes are rejected: nothing is staged and the pointer holds. A stop then starts no busy window and the array is left unchanged.
- R8: While busy is high, read requests, pointer loads, data bytes and stops are ignored. rd_valid stays low and the pointer is unchanged.
- R9: The array does not change until the busy window ends. After that, reads return the committed bytes.
- R10: After a write, the pointer holds the last written address plus one, wrapped inside the page. A current-address read then returns that location.
- R11: Inputs are served in priority order read, load, data byte, stop. A pointer load or read request discards any staged bytes that have not been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load the pointer from addr_in |
| addr_in | input | 10 | New pointer value |
| wr_byte | input | 1 | Received data byte is valid |
| wr_data | input | 8 | Received data byte |
| rd_req | input | 1 | Fetch the byte at the pointer |
| stop | input | 1 | Stop condition seen on the bus |
| wp | input | 1 | Write protect level |
| rd_data | output | 8 | Byte fetched by the last read request |
| rd_valid | output | 1 | rd_data is valid (one cycle) |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The bench targets pointer wrap in its two forms. A page write that runs past 16 bytes must wrap within the page; a design that carried into bit 4 would write the next page and leave the first byte intact. A sequential read across 1023 must wrap to 0; a page-only increment would repeat the page instead. The bench fires every command kind during busy, which catches a design that lets a command leak through and move the pointer or produce a read. It also checks that a partial page leaves its neighbours untouched, and that a dummy write or a protected write raises no busy window. A design that committed stale mask lanes or started a cycle without data would fail these checks.

// File: rtl/ee_seq_pkg.sv
package ee_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_HOLD  = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;

endpackage

// File: rtl/ee_word_ptr.sv
module ee_word_ptr #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_page,
  input  logic              step_full,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_en;

  assign ptr_en = load_en | step_page | step_full;

  always_comb begin
    ptr_d = ptr_q;
    if (load_en) begin
      ptr_d = load_val;
    end else if (step_full) begin
      ptr_d = ptr_q + 1'b1;
    end else if (step_page) begin
      ptr_d = {ptr_q[ADDR_W-1:LANE_W], ptr_q[LANE_W-1:0] + 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  parameter int LANE_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [LANE_W-1:0] rd_lane,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_lane_vld,
  output logic              any_vld
);

  logic [PAGE_BYTES-1:0][DATA_W-1:0] data_q;
  logic [PAGE_BYTES-1:0]             mask_q;
  logic [PAGE_BYTES-1:0]             mask_d;
  logic [PAGE_BYTES-1:0]             lane_hit;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    assign lane_hit[g] = wr_en && (wr_lane == LANE_W'(g));
  end

  // Data lanes carry no reset; the mask qualifies them.
  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (lane_hit[i]) begin
        data_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (clr) begin
      mask_d = '0;
    end else begin
      mask_d = mask_q | lane_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (clr || wr_en) begin
      mask_q <= mask_d;
    end
  end

  assign rd_data     = data_q[rd_lane];
  assign rd_lane_vld = mask_q[rd_lane];
  assign any_vld     = |mask_q;

endmodule

// File: rtl/ee_commit_seq.sv
module ee_commit_seq
  import ee_seq_pkg::*;
#(
  parameter int BUSY_CYCLES = 2_000_000,
  parameter int PAGE_BYTES  = 16,
  parameter int LANE_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              drain_en,
  output logic [LANE_W-1:0] drain_lane,
  output logic              done
);

  localparam int HOLD_LEN = BUSY_CYCLES - PAGE_BYTES;
  localparam int CNT_W    = $clog2(BUSY_CYCLES + 1);

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              hold_last;
  logic              lane_last;

  assign hold_last = (cnt_q == CNT_W'(HOLD_LEN - 1));
  assign lane_last = (lane_q == LANE_W'(PAGE_BYTES - 1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    lane_d = lane_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          st_d  = SEQ_HOLD;
          cnt_d = '0;
        end
      end
      SEQ_HOLD: begin
        if (hold_last) begin
          st_d   = SEQ_DRAIN;
          lane_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_DRAIN: begin
        if (lane_last) begin
          st_d = SEQ_IDLE;
        end else begin
          lane_d = lane_q + 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      lane_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      lane_q <= lane_d;
    end
  end

  assign busy       = (st_q != SEQ_IDLE);
  assign drain_en   = (st_q == SEQ_DRAIN);
  assign drain_lane = lane_q;
  assign done       = drain_en && lane_last;

endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells_q[i] <= '0;
      end
    end else if (we) begin
      cells_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (re) begin
      rdata_q <= cells_q[raddr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/eeprom_page_sequencer.sv
module eeprom_page_sequencer #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 2_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_byte,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              stop,
  input  logic              wp,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy
);

  localparam int LANE_W = $clog2(PAGE_BYTES);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [ADDR_W-1:0] word_ptr;
  logic              seq_busy;
  logic              drain_en;
  logic [LANE_W-1:0] drain_lane;
  logic              drain_done;
  logic [DATA_W-1:0] stage_byte;
  logic              stage_vld;
  logic              stage_any;

  // Command decode, priority read > load > byte > stop, all gated by busy.
  logic idle;
  logic rd_go, ld_go, wb_go, st_go, commit_go, stage_clr;

  assign idle      = !seq_busy;
  assign rd_go     = idle && rd_req;
  assign ld_go     = idle && !rd_req && addr_load;
  assign wb_go     = idle && !rd_req && !addr_load && wr_byte && !wp;
  assign st_go     = idle && !rd_req && !addr_load && !wr_byte && stop;
  assign commit_go = st_go && stage_any && !wp;
  assign stage_clr = rd_go || ld_go || (st_go && !commit_go) || drain_done;

  ee_word_ptr #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en   (ld_go),
    .load_val  (addr_in),
    .step_page (wb_go),
    .step_full (rd_go),
    .ptr       (word_ptr)
  );

  ee_page_buf #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W),
    .LANE_W     (LANE_W)
  ) u_buf (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_en       (wb_go),
    .wr_lane     (word_ptr[LANE_W-1:0]),
    .wr_data     (wr_data),
    .clr         (stage_clr),
    .rd_lane     (drain_lane),
    .rd_data     (stage_byte),
    .rd_lane_vld (stage_vld),
    .any_vld     (stage_any)
  );

  ee_commit_seq #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .PAGE_BYTES  (PAGE_BYTES),
    .LANE_W      (LANE_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (commit_go),
    .busy       (seq_busy),
    .drain_en   (drain_en),
    .drain_lane (drain_lane),
    .done       (drain_done)
  );

  ee_mem_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (drain_en && stage_vld),
    .waddr ({word_ptr[ADDR_W-1:LANE_W], drain_lane}),
    .wdata (stage_byte),
    .re    (rd_go),
    .raddr (word_ptr),
    .rdata (rd_data)
  );

  logic rd_valid_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_go;
    end
  end

  assign rd_valid = rd_valid_q;
  assign busy     = seq_busy;

endmodule

// File: rtl/ee_seq_chk.sv
module ee_seq_chk #(
  parameter int ADDR_W      = 10,
  parameter int LANE_W      = 4,
  parameter int BUSY_CYCLES = 2_000_000
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              rd_req,
  input logic              addr_load,
  input logic              wr_byte,
  input logic              stop,
  input logic              wp,
  input logic              busy,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] word_ptr
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 2);

  logic [CNT_W-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_cnt <= '0;
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end else begin
      run_cnt <= '0;
    end
  end

  logic byte_taken;
  assign byte_taken = !busy && !rd_req && !addr_load && wr_byte && !wp;

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy) |-> $past(stop));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(busy) |-> (run_cnt == CNT_W'(BUSY_CYCLES)));

  // R2
  read_serve_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_req && !busy) |=> rd_valid);

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && rd_req) |=> !rd_valid);

  // R8
  busy_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && $past(busy)) |-> $stable(word_ptr));

  // R7
  protect_stop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && wp && stop) |=> !busy);

  // R4
  page_bits_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    byte_taken |=> $stable(word_ptr[ADDR_W-1:LANE_W]));

  // R4
  lane_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    byte_taken |=> (word_ptr[LANE_W-1:0] == LANE_W'($past(word_ptr[LANE_W-1:0]) + 1'b1)));

endmodule

bind eeprom_page_sequencer ee_seq_chk #(
  .ADDR_W      (ADDR_W),
  .LANE_W      (LANE_W),
  .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .rd_req    (rd_req),
  .addr_load (addr_load),
  .wr_byte   (wr_byte),
  .stop      (stop),
  .wp        (wp),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .word_ptr  (word_ptr)
);

// File: tb/eeprom_page_sequencer_tb.sv
`timescale 1ns/1ps
module eeprom_page_sequencer_tb;

  localparam int AW   = 10;
  localparam int DW   = 8;
  localparam int PG   = 16;
  localparam int BUSY = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_load = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          wr_byte = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_req = 1'b0;
  logic          stop = 1'b0;
  logic          wp = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          busy;

  always #2.5 clk = ~clk;

  eeprom_page_sequencer #(
    .ADDR_W (AW), .DATA_W (DW), .PAGE_BYTES (PG), .BUSY_CYCLES (BUSY)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .addr_load (addr_load), .addr_in (addr_in),
    .wr_byte (wr_byte), .wr_data (wr_data), .rd_req (rd_req), .stop (stop),
    .wp (wp), .rd_data (rd_data), .rd_valid (rd_valid), .busy (busy)
  );

  // Behavioural reference model
  int m_mem [1024];
  int m_stage [16];
  int m_mask;
  int m_ptr;
  int m_left;
  int m_rd;
  bit m_rv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_mask = 0; m_ptr = 0; m_left = 0; m_rv = 0; m_rd = 0;
    end else begin
      m_rv = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          for (int l = 0; l < 16; l++)
            if (m_mask[l]) m_mem[(m_ptr / 16) * 16 + l] = m_stage[l];
          m_mask = 0;
        end
      end else if (rd_req) begin
        m_rd = m_mem[m_ptr]; m_rv = 1; m_ptr = (m_ptr + 1) % 1024; m_mask = 0;
      end else if (addr_load) begin
        m_ptr = int'(addr_in); m_mask = 0;
      end else if (wr_byte && !wp) begin
        m_stage[m_ptr % 16] = int'(wr_data);
        m_mask = m_mask | (1 << (m_ptr % 16));
        m_ptr = (m_ptr / 16) * 16 + ((m_ptr + 1) % 16);
      end else if (stop) begin
        if (m_mask != 0 && !wp) m_left = BUSY;
        else m_mask = 0;
      end
    end
  end

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  bit    armed   = 0;
  string cur_req = "R1";

  always @(negedge clk) begin
    if (armed) begin
      vectors++;
      if (busy !== (m_left > 0)) begin
        errors++;
        $display("FAIL %s busy: actual %0b expected %0b", cur_req, busy, m_left > 0);
      end
      if (rd_valid !== m_rv) begin
        errors++;
        $display("FAIL %s rd_valid: actual %0b expected %0b", cur_req, rd_valid, m_rv);
      end else if (m_rv && (int'(rd_data) != m_rd)) begin
        errors++;
        $display("FAIL %s rd_data: actual %02h expected %02h", cur_req, rd_data, m_rd[7:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL %s watchdog: actual %0d cycles expected fewer", cur_req, cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic idle_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_rd();
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic do_ld(input int a);
    @(negedge clk); addr_load = 1'b1; addr_in = AW'(a);
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic do_wb(input int d);
    @(negedge clk); wr_byte = 1'b1; wr_data = DW'(d);
    @(negedge clk); wr_byte = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    idle_cyc(2);
  endtask

  initial begin
    idle_cyc(3);
    rst_n = 1'b1;
    idle_cyc(4);
    armed = 1;

    // R1: idle outputs and zeroed array after reset
    cur_req = "R1";
    idle_cyc(3);
    do_rd(); do_rd();

    // R3: dummy write loads pointer, no busy
    cur_req = "R3";
    do_ld(12'h105); do_stop(); idle_cyc(3);
    do_rd();

    // R5 R6 R9: partial page write of three bytes
    cur_req = "R6";
    do_ld(12'h105); do_wb(8'hA1); do_wb(8'hB2); do_wb(8'hC3); do_stop();
    cur_req = "R9";
    do_rd();
    wait_idle();
    cur_req = "R5";
    do_ld(12'h100);
    for (int i = 0; i < 16; i++) do_rd();

    // R4 R10: 20 bytes into page 0x2F0, wrap inside the page
    cur_req = "R4";
    do_ld(12'h2FA);
    for (int i = 0; i < 20; i++) do_wb(8'h40 + i);
    do_stop(); wait_idle();
    cur_req = "R10";
    do_rd(); do_rd();
    cur_req = "R4";
    do_ld(12'h2F0);
    for (int i = 0; i < 18; i++) do_rd();

    // R7: protected write stages nothing
    cur_req = "R7";
    wp = 1'b1;
    do_ld(12'h050); do_wb(8'h99); do_wb(8'h98); do_stop();
    idle_cyc(3);
    wp = 1'b0;
    do_rd(); do_rd();

    // R8: every command during busy is ignored
    do_ld(12'h3F0);
    for (int i = 0; i < 16; i++) do_wb(8'hE0 + i);
    do_stop();
    cur_req = "R8";
    do_rd(); do_ld(12'h000); do_wb(8'h11); do_stop();
    wait_idle();
    do_rd();

    // R2: sequential read across the top of the array
    cur_req = "R2";
    do_ld(12'h3FD);
    for (int i = 0; i < 6; i++) do_rd();

    // R11: load discards staged bytes, stop then starts nothing
    cur_req = "R11";
    do_ld(12'h200); do_wb(8'h77); do_ld(12'h200); do_stop();
    idle_cyc(3);
    do_rd();

    idle_cyc(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule